// File: doc/BRIEF.md
# SDRAM Command Decoder and Mode Register

This block is the front end of a two-bank synchronous DRAM device model. On every rising clock edge it samples chip select, the three strobes (row, column, write) and clock enable. It turns them into exactly one command: activate, read, write, precharge, auto refresh, self refresh, mode set, burst stop, no-op or deselect. Every decoded command leaves the block as a one-cycle strobe, together with the bank, row and column fields and the auto-precharge and close-all qualifiers carried on address bit 8.

The block also holds the device mode word. It checks each field against its legal codes and presents the result as a burst length in words, a burst order, a read latency in cycles and a write burst policy. A per-bank open flag follows activates, precharges and auto-precharging accesses. Commands that break bank rules are flagged for one cycle. Reserved mode codes set a sticky error flag. Array storage, data movement and analog timing are handled by other parts of the model.

Top module: `sdram_cmd_front`

## Requirements
- R1: The strobe outputs are registered. The strobe for a command sampled at edge N is high for the one cycle after edge N, and at most one strobe is high at a time. With chip select low, the strobes {ras_n,cas_n,we_n} decode as: 011 activate, 101 read, 100 write, 010 precharge, 000 mode set, 110 burst stop, 111 no-op (no strobe).
- R2: While cs_n is high, no strobe fires, no bank flag changes and the mode fields do not change, whatever the other inputs are.
- R3: Code 001 gives auto refresh when cke is high and self refresh when cke is low.
- R4: cmd_bank and cmd_row hold the ba and addr values of the last command other than no-op or deselect. cmd_col is addr[COL_W-1:0]. cmd_autopre pulses with a read or write that had addr[8] high. cmd_pre_all pulses with a precharge that had addr[8] high.
- R5: A mode set writes burst_len from addr[2:0]: 000→1, 001→2, 010→4, 011→8, 111→full page (2^COL_W words). Other codes are reserved and keep the old length.
- R6: addr[3] selects the burst order (0 sequential, 1 interleave). Full page with interleave is rejected: in that case, and for any reserved length code, both the length and the order keep their previous values.
- R7: addr[6:4] gives the read latency: 010→2 and 011→3. All other codes are reserved and keep the previous latency.
- R8: Any reserved length, order or latency code in a mode set that is otherwise allowed sets mode_err. mode_err stays high until reset.
- R9: addr[9] sets wr_single (1 means single-word writes). A mode set with addr[8:7] other than 00 changes no field and sets mode_err.
- R10: A mode set while any bank is open raises illegal_cmd, changes no mode field and leaves mode_err as it was.
- R11: Activate opens the addressed bank. Precharge with addr[8] low closes the bank on ba, and with addr[8] high closes both banks. A legal read or write with addr[8] high closes its bank. The flags are visible one cycle after the sampling edge.
- R12: illegal_cmd pulses for one cycle with: an activate to an open bank, a read or write to a closed bank, and auto or self refresh while any bank is open. The bank flags are then left as they were.
- R13: After reset: no strobes, both banks closed, burst length 1, sequential order, latency 3, burst writes, and both error flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; picks self refresh over auto refresh |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W (1) | Bank select |
| addr | input | ROW_W (11) | Address / mode word |
| cmd_act | output | 1 | Activate strobe |
| cmd_rd | output | 1 | Read strobe |
| cmd_wr | output | 1 | Write strobe |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_aref | output | 1 | Auto refresh strobe |
| cmd_sref | output | 1 | Self refresh strobe |
| cmd_mrs | output | 1 | Mode set strobe |
| cmd_bst | output | 1 | Burst stop strobe |
| cmd_bank | output | BA_W (1) | Bank of last command |
| cmd_row | output | ROW_W (11) | Row/address of last command |
| cmd_col | output | COL_W (8) | Column of last command |
| cmd_autopre | output | 1 | Read/write with auto precharge |
| cmd_pre_all | output | 1 | Precharge of every bank |
| burst_len | output | COL_W+1 (9) | Burst length in words |
| burst_ilv | output | 1 | 1 = interleaved order |
| cas_lat | output | 2 | Read latency in cycles |
| wr_single | output | 1 | 1 = single-word writes |
| bank_open | output | NBANK (2) | Per-bank open flag |
| illegal_cmd | output | 1 | One-cycle bank-rule violation |
| mode_err | output | 1 | Sticky reserved-code error |

## Verification
The bench covers all 32 combinations of clock enable and the four command pins. A decoder that ignores chip select, or swaps refresh with self refresh, produces a wrong or extra strobe. A full sweep of length code, order and latency code is compared against a model kept in the bench. It catches the corner cases a design could get wrong: a full page burst combined with interleave, a reserved code that clears an older field, and an error flag that drops back. Bank-state sequences check that a double activate, an access to a closed bank, a refresh or mode set with a bank open, and a single-bank precharge next to a close-all precharge each set the expected flags. A design that closed the wrong bank, or that honoured a blocked mode set, would show a wrong open mask or wrong mode fields.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    C_NOP, C_DESEL, C_ACT, C_RD, C_WR, C_PRE, C_AREF, C_SREF, C_MRS, C_BST
  } cmd_e;

  // Pin decode; ras/cas/we as a 3-bit code, cke splits the refresh pair.
  function automatic cmd_e f_decode(input logic cs_n, input logic ras_n,
                                    input logic cas_n, input logic we_n,
                                    input logic cke);
    if (cs_n) return C_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b011:  return C_ACT;
      3'b101:  return C_RD;
      3'b100:  return C_WR;
      3'b010:  return C_PRE;
      3'b001:  return cke ? C_AREF : C_SREF;
      3'b000:  return C_MRS;
      3'b110:  return C_BST;
      default: return C_NOP;
    endcase
  endfunction

  // Length code legality; full page only with sequential order.
  function automatic logic f_len_ok(input logic [2:0] code, input logic ilv);
    return (code <= 3'd3) || (code == 3'd7 && !ilv);
  endfunction

  function automatic logic f_lat_ok(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3);
  endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
  import sdc_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb cmd = f_decode(cs_n, ras_n, cas_n, we_n, cke);
endmodule

// File: rtl/sdc_mode_reg.sv
module sdc_mode_reg
  import sdc_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [9:0]       word,
  output logic [COL_W:0]   burst_len,
  output logic             burst_ilv,
  output logic [1:0]       cas_lat,
  output logic             wr_single,
  output logic             mode_err
);
  localparam int LEN_W = COL_W + 1;

  function automatic logic [LEN_W-1:0] f_len_words(input logic [2:0] code);
    return (code == 3'd7) ? (LEN_W'(1) << COL_W) : (LEN_W'(1) << code);
  endfunction

  logic test_ok, len_ok, lat_ok, len_take, lat_take, base_take, err_hit;

  assign test_ok   = (word[8:7] == 2'b00);
  assign len_ok    = f_len_ok(word[2:0], word[3]);
  assign lat_ok    = f_lat_ok(word[6:4]);
  assign base_take = set_en && test_ok;
  assign len_take  = base_take && len_ok;
  assign lat_take  = base_take && lat_ok;
  assign err_hit   = set_en && !(test_ok && len_ok && lat_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_len <= LEN_W'(1);
      burst_ilv <= 1'b0;
      cas_lat   <= 2'd3;
      wr_single <= 1'b0;
      mode_err  <= 1'b0;
    end else begin
      if (len_take) begin
        burst_len <= f_len_words(word[2:0]);
        burst_ilv <= word[3];
      end
      if (lat_take)  cas_lat   <= word[5:4];
      if (base_take) wr_single <= word[9];
      if (err_hit)   mode_err  <= 1'b1;
    end
  end
endmodule

// File: rtl/sdc_bank_track.sv
module sdc_bank_track
  import sdc_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int BA_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic             ap_bit,
  output logic [NBANK-1:0] bank_open,
  output logic             any_open,
  output logic             rule_break
);
  logic hit_open;
  assign hit_open = bank_open[ba];
  assign any_open = |bank_open;

  always_comb begin
    unique case (cmd)
      C_ACT:          rule_break = hit_open;
      C_RD, C_WR:     rule_break = !hit_open;
      C_AREF, C_SREF,
      C_MRS:          rule_break = any_open;
      default:        rule_break = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic sel, opens, closes;
    assign sel    = (ba == BA_W'(g));
    assign opens  = (cmd == C_ACT) && sel;
    assign closes = ((cmd == C_PRE) && (ap_bit || sel)) ||
                    (((cmd == C_RD) || (cmd == C_WR)) && sel && ap_bit);
    always_ff @(posedge clk) begin
      if (!rst_n)      bank_open[g] <= 1'b0;
      else if (opens)  bank_open[g] <= 1'b1;
      else if (closes) bank_open[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdc_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int ROW_W = 11,
  parameter int COL_W = 8,
  parameter int AP_BIT = 8,
  localparam int BA_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  addr,
  output logic              cmd_act,
  output logic              cmd_rd,
  output logic              cmd_wr,
  output logic              cmd_pre,
  output logic              cmd_aref,
  output logic              cmd_sref,
  output logic              cmd_mrs,
  output logic              cmd_bst,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_autopre,
  output logic              cmd_pre_all,
  output logic [COL_W:0]    burst_len,
  output logic              burst_ilv,
  output logic [1:0]        cas_lat,
  output logic              wr_single,
  output logic [NBANK-1:0]  bank_open,
  output logic              illegal_cmd,
  output logic              mode_err
);
  cmd_e cmd_now;
  logic any_open, rule_break, mrs_go, ap_now, is_access, real_cmd;

  sdc_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd(cmd_now)
  );

  assign ap_now    = addr[AP_BIT];
  assign is_access = (cmd_now == C_RD) || (cmd_now == C_WR);
  assign real_cmd  = (cmd_now != C_NOP) && (cmd_now != C_DESEL);
  assign mrs_go    = (cmd_now == C_MRS) && !any_open;

  sdc_bank_track #(.NBANK(NBANK), .BA_W(BA_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_now), .ba(ba), .ap_bit(ap_now),
    .bank_open(bank_open), .any_open(any_open), .rule_break(rule_break)
  );

  sdc_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .set_en(mrs_go), .word(addr[9:0]),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
    .wr_single(wr_single), .mode_err(mode_err)
  );

  logic [ROW_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_act <= 1'b0; cmd_rd <= 1'b0; cmd_wr <= 1'b0; cmd_pre <= 1'b0;
      cmd_aref <= 1'b0; cmd_sref <= 1'b0; cmd_mrs <= 1'b0; cmd_bst <= 1'b0;
      cmd_autopre <= 1'b0; cmd_pre_all <= 1'b0; illegal_cmd <= 1'b0;
      cmd_bank <= '0; addr_q <= '0;
    end else begin
      cmd_act     <= (cmd_now == C_ACT);
      cmd_rd      <= (cmd_now == C_RD);
      cmd_wr      <= (cmd_now == C_WR);
      cmd_pre     <= (cmd_now == C_PRE);
      cmd_aref    <= (cmd_now == C_AREF);
      cmd_sref    <= (cmd_now == C_SREF);
      cmd_mrs     <= (cmd_now == C_MRS);
      cmd_bst     <= (cmd_now == C_BST);
      cmd_autopre <= is_access && ap_now;
      cmd_pre_all <= (cmd_now == C_PRE) && ap_now;
      illegal_cmd <= rule_break;
      if (real_cmd) begin
        cmd_bank <= ba;
        addr_q   <= addr;
      end
    end
  end

  assign cmd_row = addr_q;
  assign cmd_col = addr_q[COL_W-1:0];
endmodule

// File: rtl/sdc_front_chk.sv
module sdc_front_chk #(
  parameter int NBANK = 2,
  parameter int COL_W = 8,
  parameter int BA_W  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic [7:0]       strobes,
  input logic             cmd_mrs,
  input logic             cmd_act,
  input logic             cmd_pre,
  input logic             cmd_pre_all,
  input logic [BA_W-1:0]  cmd_bank,
  input logic [NBANK-1:0] bank_open,
  input logic             illegal_cmd,
  input logic [COL_W:0]   burst_len,
  input logic             burst_ilv,
  input logic [1:0]       cas_lat,
  input logic             wr_single,
  input logic             mode_err
);
  localparam logic [COL_W:0] FULL = (COL_W+1)'(1) << COL_W;

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (strobes == 8'd0));

  p_full_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_len == FULL) |-> !burst_ilv);

  p_lat_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2) || (cas_lat == 2'd3));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  p_mrs_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mrs && illegal_cmd) |-> $stable({burst_len, burst_ilv, cas_lat, wr_single}));

  p_act_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> bank_open[cmd_bank]);

  p_pre_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre && cmd_pre_all) |-> (bank_open == '0));
endmodule

bind sdram_cmd_front sdc_front_chk #(.NBANK(NBANK), .COL_W(COL_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
  .strobes({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_aref, cmd_sref, cmd_mrs, cmd_bst}),
  .cmd_mrs(cmd_mrs), .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_pre_all(cmd_pre_all),
  .cmd_bank(cmd_bank), .bank_open(bank_open), .illegal_cmd(illegal_cmd),
  .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
  .wr_single(wr_single), .mode_err(mode_err)
);

// File: tb/sdram_cmd_front_bench.sv
module sdram_cmd_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [0:0] ba = 1'b0;
  logic [10:0] addr = '0;
  logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_aref, cmd_sref, cmd_mrs, cmd_bst;
  logic [0:0] cmd_bank;
  logic [10:0] cmd_row;
  logic [7:0] cmd_col;
  logic cmd_autopre, cmd_pre_all, burst_ilv, wr_single, illegal_cmd, mode_err;
  logic [8:0] burst_len;
  logic [1:0] cas_lat, bank_open;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdram_cmd_front u_sdram_cmd_front (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_aref(cmd_aref), .cmd_sref(cmd_sref), .cmd_mrs(cmd_mrs), .cmd_bst(cmd_bst),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_autopre(cmd_autopre), .cmd_pre_all(cmd_pre_all),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
    .wr_single(wr_single), .bank_open(bank_open), .illegal_cmd(illegal_cmd),
    .mode_err(mode_err)
  );

  function automatic logic [7:0] strb();
    return {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_aref, cmd_sref, cmd_mrs, cmd_bst};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic k, input logic c, input logic r, input logic a,
                     input logic w, input logic b, input logic [10:0] ad);
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
    @(posedge clk); #1;
    cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  // expected strobe vector from pins: {act,rd,wr,pre,aref,sref,mrs,bst}
  function automatic logic [7:0] exp_strb(input logic k, input logic c, input logic r,
                                          input logic a, input logic w);
    logic [7:0] v = 8'd0;
    if (!c) begin
      v[7] = !r &&  a &&  w;
      v[6] =  r && !a &&  w;
      v[5] =  r && !a && !w;
      v[4] = !r &&  a && !w;
      v[3] = !r && !a &&  w &&  k;
      v[2] = !r && !a &&  w && !k;
      v[1] = !r && !a && !w;
      v[0] =  r &&  a && !w;
    end
    return v;
  endfunction

  initial begin
    logic [8:0] m_bl; logic m_ilv; logic [1:0] m_cl; logic m_ws, m_err;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 strobes", strb(), 0);
    check("R13 banks", bank_open, 0);
    check("R13 mode", {burst_len, burst_ilv, cas_lat, wr_single}, {9'd1, 1'b0, 2'd3, 1'b0});
    check("R13 errors", {illegal_cmd, mode_err}, 0);

    // bank sequence
    cyc(1,0,0,1,1, 0, 11'h5A5);                   // activate bank 0
    check("R11 act opens", bank_open, 2'b01);
    check("R4 row field", {cmd_bank, cmd_row}, {1'b0, 11'h5A5});
    check("R12 act legal", illegal_cmd, 0);
    cyc(1,0,0,1,1, 0, 11'h001);                   // activate open bank
    check("R12 act open bank", {illegal_cmd, bank_open}, {1'b1, 2'b01});
    cyc(1,0,1,0,1, 1, 11'h004);                   // read closed bank 1
    check("R12 read closed", {illegal_cmd, cmd_rd, cmd_bank}, {1'b1, 1'b1, 1'b1});
    cyc(1,0,1,0,0, 0, 11'h03C);                   // write bank 0
    check("R4 col field", {illegal_cmd, cmd_wr, cmd_col, cmd_autopre}, {1'b0, 1'b1, 8'h3C, 1'b0});
    cyc(1,0,0,1,1, 1, 11'h010);                   // activate bank 1
    check("R11 both open", bank_open, 2'b11);
    cyc(1,0,0,0,0, 0, 11'h022);                   // mode set with banks open
    check("R10 mrs blocked", {illegal_cmd, cmd_mrs}, 2'b11);
    check("R10 mode kept", {burst_len, cas_lat, mode_err}, {9'd1, 2'd3, 1'b0});
    cyc(1,0,0,0,1, 0, 11'h000);                   // auto refresh with open banks
    check("R12 refresh open", {illegal_cmd, cmd_aref}, 2'b11);
    cyc(1,0,0,1,0, 1, 11'h000);                   // precharge bank 1 only
    check("R11 pre single", {bank_open, cmd_pre_all}, {2'b01, 1'b0});
    cyc(1,0,1,0,1, 0, 11'h105);                   // read bank 0 auto precharge
    check("R11 autopre close", {cmd_autopre, bank_open, illegal_cmd}, {1'b1, 2'b00, 1'b0});
    cyc(1,0,0,1,1, 1, 11'h000);
    cyc(1,0,0,1,1, 0, 11'h000);
    check("R11 reopen", bank_open, 2'b11);
    cyc(1,0,0,1,0, 0, 11'h100);                   // precharge all
    check("R11 pre all", {cmd_pre_all, bank_open}, {1'b1, 2'b00});
    cyc(0,0,0,0,1, 0, 11'h000);                   // self refresh
    check("R3 self refresh", {strb(), illegal_cmd}, {8'b0000_0100, 1'b0});
    cyc(1,1,0,1,1, 1, 11'h000);                   // deselected activate
    check("R2 deselect", {strb(), bank_open}, {8'd0, 2'b00});

    // full pin sweep; close banks after each step
    for (int i = 0; i < 32; i++) begin
      logic [4:0] v = 5'(i);
      cyc(v[4], v[3], v[2], v[1], v[0], 0, 11'h030);
      check("R1/R2/R3 decode", strb(), exp_strb(v[4], v[3], v[2], v[1], v[0]));
      cyc(1,0,0,1,0, 0, 11'h100);
    end
    check("R2 mode untouched", {burst_len, cas_lat, mode_err}, {9'd1, 2'd3, 1'b0});

    // test-mode bits set: nothing changes, error raised (R9)
    cyc(1,0,0,0,0, 0, 11'h2A3);                   // A9=1,A8..7=01,cl=2,ilv=0,bl=8
    check("R9 test bits", {burst_len, burst_ilv, cas_lat, wr_single, mode_err},
          {9'd1, 1'b0, 2'd3, 1'b0, 1'b1});

    // reset, then mode sweep against a model
    rst_n = 1'b0; @(posedge clk); @(posedge clk); #1; rst_n = 1'b1; @(negedge clk);
    check("R8 err cleared by reset", mode_err, 0);
    m_bl = 9'd1; m_ilv = 1'b0; m_cl = 2'd3; m_ws = 1'b0; m_err = 1'b0;
    for (int t = 0; t < 128; t++) begin
      logic [2:0] bl = 3'(t % 8);
      logic il = 1'((t / 8) % 2);
      logic [2:0] cl = 3'(t / 16);
      logic ws = 1'(t % 3 == 0);
      logic okb = (bl <= 3'd3) || (bl == 3'd7 && !il);
      logic okc = (cl == 3'd2) || (cl == 3'd3);
      if (okb) begin m_bl = (bl == 3'd7) ? 9'd256 : (9'd1 << bl); m_ilv = il; end
      if (okc) m_cl = cl[1:0];
      m_ws = ws;
      if (!(okb && okc)) m_err = 1'b1;
      cyc(1,0,0,0,0, 0, {1'b0, ws, 2'b00, cl, il, bl});
      check("R5/R6/R7/R8/R9 mode", {burst_len, burst_ilv, cas_lat, wr_single, mode_err},
            {m_bl, m_ilv, m_cl, m_ws, m_err});
    end
    summary();
  end
endmodule